// File: doc/BRIEF.md
# Double-Buffered Flash Page Program Staging

This block gathers the words of one flash page for a page-programmed flash array. A page is 1024 bits, held as thirty-two 32-bit words in a primary assembly buffer. The assembly buffer drives the page-data output that feeds the program engine. Software writes words one at a time by index. It then issues a program command that carries a page address. While that page is being programmed, the assembly buffer is frozen. Writes that arrive during that time are steered into a secondary 32-word buffer, so the next page can be staged without waiting.

When a program operation finishes and the secondary buffer holds a complete page, that page moves into the assembly buffer in a single cycle. The secondary buffer is then marked empty, so the next program command can be issued at once. Each page needs its own program command. The program engine runs from a separate 25 MHz clock. Here it is modelled as a stub that stays busy for a fixed number of its own cycles. The command and the completion cross between the two clocks as toggles through two-flop synchronizers.

Top module: `flash_page_stager`

## Requirements
- R1: Synchronous reset (rst on clk, prst on pclk) clears busy, done, wr_err, start_err and sec_full, and sets every bit of pg_data to zero.
- R2: While busy is low, a write (wr_en high) of wr_data to index wr_idx appears in pg_data bits [32*wr_idx+31 : 32*wr_idx] on the next clk edge. Word 0 sits in bits [31:0] and word 31 in bits [1023:992].
- R3: A prog_start while busy is low raises busy on the next edge and captures prog_page into pg_addr.
- R4: While busy is high, writes leave pg_data unchanged. They are stored in the secondary buffer instead.
- R5: sec_full rises once every one of the 32 indices has been written into the secondary buffer.
- R6: A write while busy is high and sec_full is high is rejected. wr_err is high for exactly the following cycle, and the secondary contents stay unchanged.
- R7: A prog_start while busy is high is rejected. It sets start_err, which stays high until reset, and leaves pg_addr and the running operation untouched.
- R8: When the program engine finishes, busy falls. On the same edge, done is high for exactly one cycle.
- R9: If sec_full is high when the operation finishes, then on the edge where busy falls pg_data takes the secondary page and sec_full clears.
- R10: If the secondary buffer is only partly written when the operation finishes, pg_data is unchanged and sec_full stays low.
- R11: A write and an accepted prog_start in the same cycle both take effect. The written word is part of the page handed to the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| pclk | input | 1 | Program clock (25 MHz) |
| prst | input | 1 | Synchronous active-high reset, program domain |
| wr_en | input | 1 | Word write strobe |
| wr_idx | input | 5 | Word index within the page |
| wr_data | input | 32 | Word value |
| prog_start | input | 1 | Program command strobe |
| prog_page | input | 11 | Page address for the command |
| busy | output | 1 | Program operation in flight |
| done | output | 1 | One-cycle completion pulse |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| start_err | output | 1 | Sticky flag for a rejected command |
| sec_full | output | 1 | Secondary buffer holds a full page |
| pg_addr | output | 11 | Page address toward the program engine |
| pg_data | output | 1024 | Page contents toward the program engine |

## Verification
Two functions can fall in the same cycle: a word write and the acceptance of a program command. The bench drives wr_en and prog_start together on one edge while the block is idle. It then checks that busy has risen, that pg_addr holds the new page, and that the word written on that edge is already present in pg_data, which is the page the engine consumes. The same pairing is repeated while busy is high with the secondary buffer full. There the write must be flagged through wr_err, the command must set start_err, and neither may disturb the frozen page.

// File: rtl/page_stage_pkg.sv
package page_stage_pkg;
  localparam int DEF_WORD_W  = 32;
  localparam int DEF_NWORDS  = 32;
  localparam int DEF_PAGE_AW = 11;

  // destination of an incoming word write
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ASM  = 2'd1,
    TGT_SEC  = 2'd2,
    TGT_REJ  = 2'd3
  } wr_tgt_e;
endpackage

// File: rtl/tgl_sync.sv
// Two-flop synchronizer for a toggle signal with edge detection in the
// destination domain; pulse is high for one destination cycle per toggle.
module tgl_sync (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tgl_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pulse = s2_q ^ s3_q;
endmodule

// File: rtl/prog_engine_stub.sv
// Program-clock stand-in for the flash program engine: on each request
// toggle it stays busy for PROG_CYCLES cycles, then toggles its ack.
module prog_engine_stub #(
  parameter int PROG_CYCLES = 20
) (
  input  logic pclk,
  input  logic prst,
  input  logic req_tgl,
  output logic ack_tgl
);
  localparam int CW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

  logic          req_pulse;
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          ack_q;

  tgl_sync u_req_sync (
    .clk    (pclk),
    .rst    (prst),
    .tgl_in (req_tgl),
    .pulse  (req_pulse)
  );

  always_ff @(posedge pclk) begin
    if (prst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q <= 1'b0;
        ack_q <= ~ack_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (req_pulse) begin
      run_q <= 1'b1;
      cnt_q <= CW'(PROG_CYCLES - 1);
    end
  end

  assign ack_tgl = ack_q;
endmodule

// File: rtl/sec_page_buf.sv
// Secondary page buffer: per-word valid mask, full when all words written,
// whole page visible in parallel for the single-cycle transfer.
module sec_page_buf #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(NWORDS)-1:0]  idx,
  input  logic [WORD_W-1:0]          wdata,
  input  logic                       clr,
  output logic                       full,
  output logic [WORD_W*NWORDS-1:0]   page
);
  logic [WORD_W-1:0] mem_q [NWORDS];
  logic [NWORDS-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= '0;
    else if (we)    vld_q[idx] <= 1'b1;
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_flat
    assign page[g*WORD_W +: WORD_W] = mem_q[g];
  end

  assign full = &vld_q;
endmodule

// File: rtl/flash_page_stager.sv
module flash_page_stager
  import page_stage_pkg::*;
#(
  parameter int WORD_W      = DEF_WORD_W,
  parameter int NWORDS      = DEF_NWORDS,
  parameter int PAGE_AW     = DEF_PAGE_AW,
  parameter int PROG_CYCLES = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pclk,
  input  logic                      prst,
  input  logic                      wr_en,
  input  logic [$clog2(NWORDS)-1:0] wr_idx,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      prog_start,
  input  logic [PAGE_AW-1:0]        prog_page,
  output logic                      busy,
  output logic                      done,
  output logic                      wr_err,
  output logic                      start_err,
  output logic                      sec_full,
  output logic [PAGE_AW-1:0]        pg_addr,
  output logic [WORD_W*NWORDS-1:0]  pg_data
);
  localparam int PAGE_W = WORD_W * NWORDS;

  logic              busy_q, done_q, wr_err_q, start_err_q, req_tgl_q;
  logic [PAGE_AW-1:0] addr_q;
  logic [WORD_W-1:0] asm_q [NWORDS];
  wr_tgt_e           tgt;
  logic              start_ok;
  logic              fin;
  logic              ack_tgl;
  logic              sec_clr;
  logic              sec_full_w;
  logic [PAGE_W-1:0] sec_page;

  // write steering: idle -> assembly, busy -> secondary unless full
  always_comb begin
    tgt = TGT_NONE;
    if (wr_en) begin
      if (!busy_q)          tgt = TGT_ASM;
      else if (!sec_full_w) tgt = TGT_SEC;
      else                  tgt = TGT_REJ;
    end
  end

  assign start_ok = prog_start && !busy_q;
  assign sec_clr  = fin && sec_full_w;

  // primary assembly buffer (frozen while busy)
  always_ff @(posedge clk) begin
    for (int i = 0; i < NWORDS; i++) begin
      if (rst)
        asm_q[i] <= '0;
      else if (sec_clr)
        asm_q[i] <= sec_page[i*WORD_W +: WORD_W];
      else if (tgt == TGT_ASM && wr_idx == ($clog2(NWORDS))'(i))
        asm_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      wr_err_q    <= 1'b0;
      start_err_q <= 1'b0;
      req_tgl_q   <= 1'b0;
      addr_q      <= '0;
    end else begin
      done_q   <= fin;
      wr_err_q <= (tgt == TGT_REJ);
      if (prog_start && busy_q) start_err_q <= 1'b1;
      if (start_ok) begin
        busy_q    <= 1'b1;
        req_tgl_q <= ~req_tgl_q;
        addr_q    <= prog_page;
      end else if (fin) begin
        busy_q <= 1'b0;
      end
    end
  end

  sec_page_buf #(
    .WORD_W (WORD_W),
    .NWORDS (NWORDS)
  ) u_sec (
    .clk   (clk),
    .rst   (rst),
    .we    (tgt == TGT_SEC),
    .idx   (wr_idx),
    .wdata (wr_data),
    .clr   (sec_clr),
    .full  (sec_full_w),
    .page  (sec_page)
  );

  prog_engine_stub #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_eng (
    .pclk    (pclk),
    .prst    (prst),
    .req_tgl (req_tgl_q),
    .ack_tgl (ack_tgl)
  );

  tgl_sync u_ack_sync (
    .clk    (clk),
    .rst    (rst),
    .tgl_in (ack_tgl),
    .pulse  (fin)
  );

  for (genvar g = 0; g < NWORDS; g++) begin : g_out
    assign pg_data[g*WORD_W +: WORD_W] = asm_q[g];
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign wr_err    = wr_err_q;
  assign start_err = start_err_q;
  assign sec_full  = sec_full_w;
  assign pg_addr   = addr_q;
endmodule

// File: rtl/flash_page_stager_chk.sv
module flash_page_stager_chk #(
  parameter int PW = 1024,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          prog_start,
  input logic          busy,
  input logic          done,
  input logic          wr_err,
  input logic          start_err,
  input logic          sec_full,
  input logic [AW-1:0] pg_addr,
  input logic [PW-1:0] pg_data
);
  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_start && !busy) |=> busy);

  // R4
  page_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(pg_data)));

  // R6
  wr_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en && busy && sec_full));

  // R7
  start_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    start_err |=> start_err);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(pg_addr)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_with_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9
  sec_drain_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(sec_full)) |-> !sec_full);
endmodule

bind flash_page_stager flash_page_stager_chk #(
  .PW (WORD_W * NWORDS),
  .AW (PAGE_AW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .prog_start (prog_start),
  .busy       (busy),
  .done       (done),
  .wr_err     (wr_err),
  .start_err  (start_err),
  .sec_full   (sec_full),
  .pg_addr    (pg_addr),
  .pg_data    (pg_data)
);

// File: tb/flash_page_stager_bench.sv
module flash_page_stager_bench;
  localparam int NV = 8;
  // {index[4:0], data[31:0]}
  localparam logic [36:0] VEC [NV] = '{
    {5'd0,  32'h1111_0000}, {5'd31, 32'hFFFF_0031}, {5'd1,  32'h2222_0001},
    {5'd16, 32'h8000_0016}, {5'd30, 32'hDEAD_BEEF}, {5'd0,  32'h0BAD_F00D},
    {5'd9,  32'h0000_0009}, {5'd15, 32'hCAFE_0015}
  };

  logic clk = 0, pclk = 0, rst = 1, prst = 1;
  logic wr_en = 0, prog_start = 0;
  logic [4:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [10:0] prog_page = '0;
  logic busy, done, wr_err, start_err, sec_full;
  logic [10:0] pg_addr;
  logic [1023:0] pg_data;
  logic [1023:0] saved;
  int total = 0, bad = 0;

  always #2 clk = ~clk;
  always #20 pclk = ~pclk;

  flash_page_stager u_flash_page_stager (
    .clk(clk), .rst(rst), .pclk(pclk), .prst(prst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .prog_start(prog_start), .prog_page(prog_page),
    .busy(busy), .done(done), .wr_err(wr_err), .start_err(start_err),
    .sec_full(sec_full), .pg_addr(pg_addr), .pg_data(pg_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic start(input logic [10:0] p);
    prog_start = 1; prog_page = p;
    @(negedge clk);
    prog_start = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk({req, " busy falls"}, 32'(busy), 32'd0);
    chk({req, " done with fall"}, 32'(done), 32'd1);
    @(negedge clk);
    chk({req, " done single"}, 32'(done), 32'd0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ref_mem [32];
    int mism;
    repeat (4) @(negedge pclk);
    @(negedge clk); rst = 0; prst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 flags", {29'd0, wr_err, start_err, sec_full}, 0);
    chk("R1 page zero", 32'(pg_data != '0), 0);

    // R2 vector table of idle writes
    for (int k = 0; k < 32; k++) ref_mem[k] = '0;
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][36:32], VEC[v][31:0]);
      ref_mem[VEC[v][36:32]] = VEC[v][31:0];
      chk("R2 word placement", pg_data[32*VEC[v][36:32] +: 32], VEC[v][31:0]);
    end
    mism = 0;
    for (int k = 0; k < 32; k++) if (pg_data[32*k +: 32] !== ref_mem[k]) mism++;
    chk("R2 whole page", 32'(mism), 0);

    // R11 same-cycle write and command
    wr_en = 1; wr_idx = 5'd7; wr_data = 32'h7777_ABCD;
    prog_start = 1; prog_page = 11'h155;
    @(negedge clk);
    wr_en = 0; prog_start = 0;
    chk("R3 busy rises", 32'(busy), 1);
    chk("R3 page address", 32'(pg_addr), 32'h155);
    chk("R11 word in started page", pg_data[32*7 +: 32], 32'h7777_ABCD);
    saved = pg_data;

    // R4/R5 fill the secondary buffer while busy
    for (int k = 0; k < 32; k++) begin
      wr(5'(k), 32'hA000_0000 | k);
      if (k < 31) chk("R5 not yet full", 32'(sec_full), 0);
    end
    chk("R4 page frozen", 32'(pg_data != saved), 0);
    chk("R5 full", 32'(sec_full), 1);

    // R6 write while full, R7 command while busy (same cycle)
    wr_en = 1; wr_idx = 5'd5; wr_data = 32'h5555_5555;
    prog_start = 1; prog_page = 11'h0AA;
    @(negedge clk);
    wr_en = 0; prog_start = 0;
    chk("R6 wr_err pulse", 32'(wr_err), 1);
    chk("R7 start_err", 32'(start_err), 1);
    chk("R7 address kept", 32'(pg_addr), 32'h155);
    chk("R4 page frozen after reject", 32'(pg_data != saved), 0);
    @(negedge clk);
    chk("R6 wr_err single", 32'(wr_err), 0);

    // R8/R9 completion with full secondary
    wait_idle("R8");
    mism = 0;
    for (int k = 0; k < 32; k++) if (pg_data[32*k +: 32] !== (32'hA000_0000 | k)) mism++;
    chk("R9 page transferred", 32'(mism), 0);
    chk("R6 rejected word absent", pg_data[32*5 +: 32], 32'hA000_0005);
    chk("R9 sec emptied", 32'(sec_full), 0);
    chk("R7 sticky", 32'(start_err), 1);

    // R10 partial secondary is not transferred
    saved = pg_data;
    start(11'h003);
    chk("R3 second start", 32'(busy), 1);
    wr(5'd2, 32'h0000_0BBB);
    wr(5'd3, 32'h0000_0CCC);
    wait_idle("R10");
    chk("R10 page unchanged", 32'(pg_data != saved), 0);
    chk("R10 sec not full", 32'(sec_full), 0);

    // R2 idle write after completion
    wr(5'd31, 32'h1234_5678);
    chk("R2 write after done", pg_data[1023:992], 32'h1234_5678);
    chk("R7 sticky end", 32'(start_err), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule